// File: doc/BRIEF.md
# Infrared transceiver module configuration master

This block talks to the control port of an external infrared transceiver module over a two-wire synchronous link. It drives a clock line and a data line toward the module. It watches two lines coming back: a data line and an active-low line that says a read answer is ready. A host places one request on a parallel interface. The block runs the whole bit-level exchange, reports the byte read back and whether the module failed to answer, and pulses done when it has finished.

Four operations exist:

- Register write.
- Register read.
- Module reset, which is a long burst of clock pulses with the data line held low.
- Mode setup. This chains a reset, three register writes and one read-back without the host stepping in between.

All link timing is built from a time unit of `presc+1` clock cycles. Every clock pulse on the link lasts three units:

- Low-first pulses drive the clock low for two units and then high for one unit. They are used while bytes are being sent.
- High-first pulses drive the clock high for one unit and then low for two units. They are used for polling, read data, resets and trailers.

Top module: `irx_module_cfg`

## Requirements
- R1: While and right after synchronous reset, `mclk`, `mdo`, `busy`, `done`, `nores` and `rdata` are all zero.
- R2: The command byte equals `addr | (index << 1) | rw`, where rw=1 for a write and rw=0 for a read. Every byte is sent least-significant bit first, on `mdo`, during a low-first pulse.
- R3: Every byte is preceded by one lead-in pulse with `mdo` high. A low-first pulse holds `mclk` low for 2 units and then high for 1 unit, with `mdo` unchanged during the high part. One unit is `presc+1` clock cycles.
- R4: A write (`req_op`=0) sends the lead-in and the command byte, then the lead-in and the data byte, then 2 low-first pulses with `mdo` low. After that the clock stays low.
- R5: A read (`req_op`=1) sends the lead-in and the command byte, then up to 10 high-first poll pulses with `mdo` low. At the end of each poll pulse `mrdv` is sampled, and polling stops at the first pulse where it is low.
- R6: Once the module has answered, 8 high-first pulses follow. `mdi` is sampled at the end of each one (after the falling clock edge) and assembled into `rdata` LSB first.
- R7: If `mrdv` stays high through all 10 polls, only 2 high-first dummy pulses follow, and `nores` is 1 at done.
- R8: Every read ends with 4 high-first pulses with `mdo` low.
- R9: A module reset (`req_op`=2) gives 30 high-first pulses with `mdo` low and then leaves the clock low.
- R10: Mode setup (`req_op`=3, mode byte on `req_wdata`, address on `req_addr`) runs these steps back to back:
  1. a reset;
  2. a write of 0x17 to index 0;
  3. a write of the mode byte to index 1;
  4. a write of 0xFF to index 2;
  5. a read of index 1.
  The read result appears on `rdata`/`nores`.
- R11: A request is accepted only while idle. `busy` rises the cycle after acceptance and stays high through a single-cycle `done`. A `req_valid` raised while busy has no effect.
- R12: `mdi` and `mrdv` pass through two flip-flops before use, so a level must be present on them from at least two clock cycles before the end of the pulse in which it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| presc | input | PW | Time unit length minus one, in clock cycles; change only while idle |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 write, 1 read, 2 module reset, 3 mode setup |
| req_addr | input | 8 | Device address |
| req_index | input | 7 | Register index |
| req_wdata | input | 8 | Write data, or mode byte for mode setup |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read back |
| nores | output | 1 | Module never signalled read-valid |
| mclk | output | 1 | Link clock |
| mdo | output | 1 | Link data out |
| mdi | input | 1 | Link data in |
| mrdv | input | 1 | Read-valid from module, active low |

## Verification
The request is taken on the edge where `req_valid` is seen. The first pulse shows on `mclk` in the very next cycle, and each pulse then lasts exactly `3*(presc+1)` cycles with no gaps between pulses. `done` comes in the one cycle after the last pulse, and at that point `rdata` and `nores` are already final. The bench builds the expected waveform cycle by cycle when the request is accepted and compares every cycle at the falling clock edge. It drives the responder lines from the first cycle of each poll or data pulse, which keeps each level ahead of the two-stage synchroniser.

// File: rtl/irx_module_cfg.sv
module irx_module_cfg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] presc,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [7:0]    req_addr,
  input  logic [6:0]    req_index,
  input  logic [7:0]    req_wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          nores,
  output logic          mclk,
  output logic          mdo,
  input  logic          mdi,
  input  logic          mrdv
);

  localparam int POLLS = 10;
  localparam int RSTP  = 30;

  typedef enum logic [3:0] {
    IDLE, LEAD1, CMD, LEAD2, WDAT, WTRL, POLL, RDAT, DUMMY, RTRL, MRST, FIN
  } st_t;

  st_t          st;
  logic [PW-1:0] pre;
  logic [1:0]   ucnt;
  logic [4:0]   pcnt;
  logic [15:0]  sh;
  logic         wr, seq;
  logic [2:0]   step;
  logic [7:0]   mode, areg;
  logic [1:0]   mdi_sr, rdv_sr;

  function automatic logic [15:0] pack(input logic [7:0] a, input logic [6:0] i,
                                       input logic w, input logic [7:0] d);
    return {d, a | {i, 1'b0} | {7'd0, w}};
  endfunction

  wire tick   = (pre == presc);
  wire pend   = tick && (ucnt == 2'd2);
  wire hfirst = st inside {POLL, RDAT, DUMMY, RTRL, MRST};
  wire last   = pend && ((st == WTRL && pcnt == 5'd1) ||
                         (st == RTRL && pcnt == 5'd3) ||
                         (st == MRST && pcnt == 5'(RSTP - 1)));
  wire [2:0] nstep = step + 3'd1;

  assign busy = (st != IDLE);
  assign done = (st == FIN);
  assign mclk = (st == IDLE || st == FIN) ? 1'b0 :
                hfirst ? (ucnt == 2'd0) : (ucnt == 2'd2);
  assign mdo  = (st == LEAD1 || st == LEAD2) ? 1'b1 :
                (st == CMD || st == WDAT) ? sh[0] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; pre <= '0; ucnt <= '0; pcnt <= '0; sh <= '0;
      wr <= 1'b0; seq <= 1'b0; step <= '0; mode <= '0; areg <= '0;
      rdata <= '0; nores <= 1'b0; mdi_sr <= '0; rdv_sr <= 2'b11;
    end else begin
      mdi_sr <= {mdi_sr[0], mdi};
      rdv_sr <= {rdv_sr[0], mrdv};
      if (st == IDLE) begin
        pre <= '0; ucnt <= '0; pcnt <= '0;
        if (req_valid) begin
          rdata <= '0; nores <= 1'b0;
          areg  <= req_addr; mode <= req_wdata; step <= '0;
          seq   <= (req_op == 2'd3);
          wr    <= (req_op == 2'd0);
          sh    <= pack(req_addr, req_index, req_op == 2'd0, req_wdata);
          st    <= (req_op[1]) ? MRST : LEAD1;
        end
      end else if (st == FIN) begin
        st <= IDLE;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) ucnt <= (ucnt == 2'd2) ? 2'd0 : ucnt + 2'd1;
        if (pend) begin
          pcnt <= pcnt + 5'd1;
          case (st)
            LEAD1: begin st <= CMD; pcnt <= '0; end
            LEAD2: begin st <= WDAT; pcnt <= '0; end
            CMD, WDAT: begin
              sh <= {1'b0, sh[15:1]};
              if (pcnt == 5'd7) begin
                pcnt <= '0;
                st   <= (st == WDAT) ? WTRL : (wr ? LEAD2 : POLL);
              end
            end
            POLL: begin
              if (!rdv_sr[1]) begin st <= RDAT; pcnt <= '0; end
              else if (pcnt == 5'(POLLS - 1)) begin
                st <= DUMMY; pcnt <= '0; nores <= 1'b1;
              end
            end
            RDAT: begin
              rdata <= {mdi_sr[1], rdata[7:1]};
              if (pcnt == 5'd7) begin st <= RTRL; pcnt <= '0; end
            end
            DUMMY: if (pcnt == 5'd1) begin st <= RTRL; pcnt <= '0; end
            default: ;
          endcase
          if (last) begin
            pcnt <= '0;
            if (seq && step != 3'd4) begin
              step <= nstep;
              st   <= LEAD1;
              wr   <= (nstep != 3'd4);
              case (nstep)
                3'd1:    sh <= pack(areg, 7'd0, 1'b1, 8'h17);
                3'd2:    sh <= pack(areg, 7'd1, 1'b1, mode);
                3'd3:    sh <= pack(areg, 7'd2, 1'b1, 8'hFF);
                default: sh <= pack(areg, 7'd1, 1'b0, 8'h00);
              endcase
            end else begin
              st <= FIN;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/irx_module_cfg_chk.sv
module irx_module_cfg_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic nores,
  input logic mclk,
  input logic mdo
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mclk && !mdo)); // R1

  AST_HIGH_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mclk && $past(mclk)) |-> $stable(mdo)); // R3

  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> !mclk); // R4

  AST_NORES_IN_TXN: assert property (@(posedge clk) disable iff (rst)
    $rose(nores) |-> busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R11

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R11

endmodule

bind irx_module_cfg irx_module_cfg_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .nores(nores), .mclk(mclk), .mdo(mdo)
);

// File: tb/sim_irx_module_cfg.sv
module sim_irx_module_cfg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] presc = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic [6:0] req_index = '0;
  logic busy, done, nores, mclk, mdo;
  logic [7:0] rdata;
  logic mdi = 1'b0, mrdv = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irx_module_cfg u0 (
    .clk(clk), .rst(rst), .presc(presc), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_index(req_index), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .nores(nores),
    .mclk(mclk), .mdo(mdo), .mdi(mdi), .mrdv(mrdv)
  );

  typedef struct {
    bit c; bit d; bit dn; bit rv; bit di; bit [7:0] rd; bit nr; string tag;
  } ent_t;

  ent_t q[$];
  int n_chk = 0, n_fail = 0, P = 0, cyc = 0;
  string tag = "R1";
  bit [7:0] exp_rd = 0;
  bit exp_nr = 0, ended = 0;
  ent_t e;
  bit eb;

  task automatic put(bit c, bit d, bit rv, bit di, int n);
    ent_t x;
    repeat (n) begin
      x.c = c; x.d = d; x.dn = 0; x.rv = rv; x.di = di; x.rd = 0; x.nr = 0; x.tag = tag;
      q.push_back(x);
    end
  endtask

  task automatic lo_pulse(bit d);
    put(0, d, 1, 0, 2*(P+1));
    put(1, d, 1, 0, P+1);
  endtask

  task automatic hi_pulse(bit rv, bit di);
    put(1, 0, rv, di, P+1);
    put(0, 0, rv, di, 2*(P+1));
  endtask

  task automatic m_byte(bit [7:0] b);
    lo_pulse(1);
    for (int k = 0; k < 8; k++) lo_pulse(b[k]);
  endtask

  task automatic m_write(bit [7:0] a, bit [6:0] i, bit [7:0] d);
    m_byte(a | {i, 1'b0} | 8'd1);
    m_byte(d);
    lo_pulse(0); lo_pulse(0);
  endtask

  task automatic m_read(bit [7:0] a, bit [6:0] i, int k, bit [7:0] v);
    m_byte(a | {i, 1'b0});
    for (int p = 0; p < 10; p++) begin
      hi_pulse(p == k ? 1'b0 : 1'b1, 0);
      if (p == k) break;
    end
    if (k < 10) for (int j = 0; j < 8; j++) hi_pulse(1, v[j]);
    else begin hi_pulse(1, 0); hi_pulse(1, 0); end
    repeat (4) hi_pulse(1, 0);
  endtask

  task automatic m_reset();
    repeat (30) hi_pulse(1, 0);
  endtask

  task automatic m_done();
    ent_t x;
    x.c = 0; x.d = 0; x.dn = 1; x.rv = 1; x.di = 0; x.rd = exp_rd; x.nr = exp_nr; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic go(bit [1:0] op, bit [7:0] a, bit [6:0] i, bit [7:0] d);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    presc = 8'(P);
    req_valid = 1; req_op = op; req_addr = a; req_index = i; req_wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic drop();
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (q.size() > 0) begin e = q.pop_front(); eb = 1; end
      else begin
        e.c = 0; e.d = 0; e.dn = 0; e.rv = 1; e.di = 0; e.rd = 0; e.nr = 0; e.tag = "R11"; eb = 0;
      end
      mrdv = e.rv; mdi = e.di;
      n_chk++;
      if (mclk !== e.c || mdo !== e.d || busy !== eb || done !== e.dn) begin
        n_fail++;
        $display("FAIL %s: clk/do/busy/done=%b%b%b%b expected %b%b%b%b at cycle %0d",
                 e.tag, mclk, mdo, busy, done, e.c, e.d, eb, e.dn, cyc);
      end
      if (e.dn) begin
        n_chk++;
        if (rdata !== e.rd || nores !== e.nr) begin
          n_fail++;
          $display("FAIL %s: rdata=%h nores=%b expected %h %b", e.tag, rdata, nores, e.rd, e.nr);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (mclk !== 0 || mdo !== 0 || busy !== 0 || done !== 0 || nores !== 0 || rdata !== 0) begin
      n_fail++;
      $display("FAIL R1: clk/do/busy/done/nores=%b%b%b%b%b rdata=%h expected 00000 00",
               mclk, mdo, busy, done, nores, rdata);
    end
    rst = 0;

    // R2 R3 R4: write at the shortest unit
    tag = "R2 R3 R4 write P0"; P = 0; exp_rd = 0; exp_nr = 0;
    go(0, 8'h40, 7'd3, 8'hA5); m_write(8'h40, 7'd3, 8'hA5); m_done(); drop();

    // R3: longer unit
    tag = "R3 R4 write P2"; P = 2;
    go(0, 8'h40, 7'd5, 8'h3C); m_write(8'h40, 7'd5, 8'h3C); m_done(); drop();

    // R5 R6 R8: answer on first poll
    tag = "R5 R6 R8 read k0"; P = 1; exp_rd = 8'h3C; exp_nr = 0;
    go(1, 8'h40, 7'd1, 8'h00); m_read(8'h40, 7'd1, 0, 8'h3C); m_done(); drop();

    // R5 R6 R12: later answer
    tag = "R5 R6 R12 read k6"; P = 0; exp_rd = 8'h81;
    go(1, 8'h40, 7'd2, 8'h00); m_read(8'h40, 7'd2, 6, 8'h81); m_done(); drop();

    // R5: answer on the last allowed poll
    tag = "R5 R6 read k9"; P = 1; exp_rd = 8'h5A;
    go(1, 8'h40, 7'd4, 8'h00); m_read(8'h40, 7'd4, 9, 8'h5A); m_done(); drop();

    // R7 R8: no answer
    tag = "R7 R8 no response"; P = 0; exp_rd = 8'h00; exp_nr = 1;
    go(1, 8'h40, 7'd1, 8'h00); m_read(8'h40, 7'd1, 10, 8'h00); m_done(); drop();

    // R9: module reset
    tag = "R9 module reset"; P = 1; exp_rd = 0; exp_nr = 0;
    go(2, 8'h00, 7'd0, 8'h00); m_reset(); m_done(); drop();

    // R10: mode setup with read-back
    tag = "R10 mode setup"; P = 0; exp_rd = 8'h55; exp_nr = 0;
    go(3, 8'h40, 7'd0, 8'h55);
    m_reset(); m_write(8'h40, 7'd0, 8'h17); m_write(8'h40, 7'd1, 8'h55);
    m_write(8'h40, 7'd2, 8'hFF); m_read(8'h40, 7'd1, 2, 8'h55); m_done(); drop();

    // R11: request while busy is ignored
    tag = "R11 ignore while busy"; P = 0; exp_rd = 0; exp_nr = 0;
    go(0, 8'h40, 7'd6, 8'hC3); m_write(8'h40, 7'd6, 8'hC3); m_done(); drop();
    repeat (20) @(negedge clk);
    req_valid = 1; req_op = 2'd2;
    @(negedge clk);
    req_valid = 0;

    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule